// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide, two-address host register interface of one interrupt controller. It decodes the initialization word sequence and the operational command words. It holds the controller's configuration: the line mask, the vector base, auto-EOI, special fully nested mode, special mask mode, the read select, a pending poll and the rotating priority offset. It owns the in-service register, clears its bits on end-of-interrupt commands and sets them when a poll read acknowledges a line.

The request register lives outside the block and arrives on `req_in`. A poll acknowledge is reported on `ack_valid`/`ack_line`, so that the request latch can drop an edge-triggered bit. A start of initialization is reported on `init_clear`, so that the latch can clear its state. A separate one-byte trigger-mode register sits on its own strobe. Only its writable bits can be set.

Top module: `irq_cmd_port`

## Requirements
- R1: After a synchronous reset the mask, in-service register, priority offset, trigger-mode register and all mode flags are 0, the initialization step is the run step, and an address-0 read returns `req_in`.
- R2: An address-0 write with bit 4 set pulses `init_clear` in its own cycle. It clears the mask, in-service register, priority offset, auto-EOI, rotate-on-auto-EOI, special fully nested mode, special mask, read select and pending poll. The trigger-mode register is left as it was.
- R3: After the start word, address-1 writes follow a step sequence. The base step loads `vec_base_o` from bits 7:3. It then moves to the run step (single and no mode word), to the mode step (single with mode word), or to the link step (cascaded). The link step moves to the mode step if a mode word is needed, otherwise to the run step. The mode step loads special fully nested mode from bit 4 and auto-EOI from bit 1. Only a run-step address-1 write loads the mask.
- R4: An address-0 write with bit 4 clear and bit 3 set is a control word. If its bit 1 is set, its bit 0 selects which register address-0 reads return: 1 returns the in-service register, 0 returns `req_in`. With bit 1 clear the selection is kept. Address-1 reads return the mask.
- R5: In a control word, bit 6 set loads special mask mode from bit 5. With bit 6 clear, special mask mode is kept.
- R6: An address-0 write with bits 4 and 3 clear is a command, and bits 7:5 give its code. Code 1 clears the in-service bit of the highest priority. Code 5 does the same and then sets the priority offset to that line + 1. Priority rank is (line − offset) mod 8, and rank 0 is highest.
- R7: Command code 3 clears the in-service bit of the line in bits 2:0. Code 6 sets the offset to (bits 2:0 + 1) mod 8. Code 7 clears the in-service bit of the line in bits 2:0 and sets the offset to that line + 1. Code 2 changes nothing.
- R8: A control word with bit 2 set makes a poll pending. While a poll is pending, reads return 0x80 OR the winning line, or 0x00 if there is no winner. A read strobe during a pending poll clears the poll. If there is a winner, the same strobe pulses `ack_valid` with `ack_line` and acknowledges the line.
- R9: The winner is the highest-rank line of `req_in` & ~mask. It wins only if its rank is strictly above the highest-rank in-service bit. Under special mask mode, masked in-service bits do not count.
- R10: An acknowledge sets the in-service bit unless auto-EOI is on. With auto-EOI on and rotate-on-auto-EOI set (command codes 0 and 4 load it from bit 7), an acknowledge instead sets the offset to line + 1.
- R11: On a primary controller with special fully nested mode on, the in-service bit of the cascade line (default 2) does not block a new request.
- R12: Trigger-mode writes store the write data ANDed with the writable-bit mask (default 0xF8).
- R13: Register updates take effect on the clock edge of the write or read strobe. `rdata` follows the address and the current state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the two-address port; takes precedence over rd_en |
| rd_en | input | 1 | Read strobe; matters only for a pending poll |
| addr | input | 1 | Register address, 0 or 1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| tm_wr_en | input | 1 | Trigger-mode register write strobe |
| tm_wdata | input | 8 | Trigger-mode write data |
| tm_rdata | output | 8 | Trigger-mode register contents |
| req_in | input | 8 | Request register from the request latch |
| ack_valid | output | 1 | Poll acknowledge pulse |
| ack_line | output | 3 | Line acknowledged |
| init_clear | output | 1 | Pulse on a start-of-initialization write |
| mask_o | output | 8 | Line mask |
| isr_o | output | 8 | In-service register |
| vec_base_o | output | 5 | Vector base (upper five bits of the vector) |
| prio_off_o | output | 3 | Priority offset: line holding rank 0 |
| auto_eoi_o | output | 1 | Auto-EOI mode |
| sfnm_o | output | 1 | Special fully nested mode |
| smm_o | output | 1 | Special mask mode |

## Verification
The bench drives each initialization path: cascaded with and without a mode word, and single with and without one. A sequencer that takes a wrong branch would load the mask, vector base or mode bits from the wrong word. Poll tests with a nonzero offset and with a line already in service catch a resolver that ignores rotation, or one that lets an equal-rank request pre-empt the in-service line. Special mask mode, special fully nested mode and auto-EOI with rotation each turn a poll result from 0x00 into a hit, or from setting the in-service bit into moving the offset. A design that gets them wrong returns the opposite result. Each end-of-interrupt code is checked on the in-service register and the offset together, and code 2 is checked to leave both alone.

// File: rtl/irq_cmd_pkg.sv
`timescale 1ns/1ps
package irq_cmd_pkg;

  localparam int LINE_W = 3;

  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_BASE = 2'd1,
    STEP_LINK = 2'd2,
    STEP_MODE = 2'd3
  } init_step_e;

  // Command codes carried in bits 7:5 of an address-0 command write
  typedef enum logic [2:0] {
    OP_ROT_CLR      = 3'd0,
    OP_EOI_HP       = 3'd1,
    OP_NOP          = 3'd2,
    OP_EOI_LINE     = 3'd3,
    OP_ROT_SET      = 3'd4,
    OP_EOI_HP_ROT   = 3'd5,
    OP_SET_PRIO     = 3'd6,
    OP_EOI_LINE_ROT = 3'd7
  } ocw_op_e;

  typedef struct packed {
    logic              start;    // begin initialization
    logic              ctl;      // control word: poll, read select, special mask
    logic              cmd;      // command word: EOI and rotation
    ocw_op_e           op;
    logic [LINE_W-1:0] line;
    logic              data_wr;  // address-1 write
  } cmd_t;

endpackage

// File: rtl/irq_cmd_decode.sv
`timescale 1ns/1ps
module irq_cmd_decode
  import irq_cmd_pkg::*;
(
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output cmd_t       dec
);

  always_comb begin
    dec.start   = wr_en & ~addr & wdata[4];
    dec.ctl     = wr_en & ~addr & ~wdata[4] & wdata[3];
    dec.cmd     = wr_en & ~addr & ~wdata[4] & ~wdata[3];
    dec.op      = ocw_op_e'(wdata[7:5]);
    dec.line    = wdata[2:0];
    dec.data_wr = wr_en & addr;
  end

endmodule

// File: rtl/irq_cmd_prio.sv
`timescale 1ns/1ps
// Finds the highest-rank set bit of vec, where rank = (line - base) mod N.
module irq_cmd_prio #(
  parameter  int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] base,
  output logic         hit,
  output logic [W-1:0] rank,
  output logic [W-1:0] line
);

  logic [N-1:0] rot;

  generate
    for (genvar g = 0; g < N; g++) begin : g_rot
      logic [W-1:0] src;
      assign src    = W'(g) + base;
      assign rot[g] = vec[src];
    end
  endgenerate

  always_comb begin
    hit  = |rot;
    rank = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) rank = W'(i);
    end
    line = rank + base;
  end

endmodule

// File: rtl/irq_cmd_init_seq.sv
`timescale 1ns/1ps
module irq_cmd_init_seq
  import irq_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_single,
  input  logic start_need_mode,
  input  logic data_wr,
  output logic run_ld,
  output logic base_ld,
  output logic mode_ld
);

  init_step_e step_q;
  logic       single_q;
  logic       need_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= STEP_RUN;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
    end else if (start) begin
      step_q      <= STEP_BASE;
      single_q    <= start_single;
      need_mode_q <= start_need_mode;
    end else if (data_wr) begin
      unique case (step_q)
        STEP_BASE: begin
          if (single_q) step_q <= need_mode_q ? STEP_MODE : STEP_RUN;
          else          step_q <= STEP_LINK;
        end
        STEP_LINK: step_q <= need_mode_q ? STEP_MODE : STEP_RUN;
        STEP_MODE: step_q <= STEP_RUN;
        default:   step_q <= STEP_RUN;
      endcase
    end
  end

  assign run_ld  = data_wr & (step_q == STEP_RUN);
  assign base_ld = data_wr & (step_q == STEP_BASE);
  assign mode_ld = data_wr & (step_q == STEP_MODE);

endmodule

// File: rtl/irq_cmd_trig.sv
`timescale 1ns/1ps
module irq_cmd_trig #(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] WR_MASK = 8'hF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata & WR_MASK;
  end

endmodule

// File: rtl/irq_cmd_port.sv
`timescale 1ns/1ps
module irq_cmd_port
  import irq_cmd_pkg::*;
#(
  parameter  int                DATA_W       = 8,
  parameter  bit                IS_PRIMARY   = 1'b1,
  parameter  int                CASCADE_LINE = 2,
  parameter  logic [DATA_W-1:0] TM_WR_MASK   = 8'hF8,
  localparam int                LW           = $clog2(DATA_W),
  localparam int                VB_W         = DATA_W - LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tm_wr_en,
  input  logic [DATA_W-1:0] tm_wdata,
  output logic [DATA_W-1:0] tm_rdata,
  input  logic [DATA_W-1:0] req_in,
  output logic              ack_valid,
  output logic [LW-1:0]     ack_line,
  output logic              init_clear,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] isr_o,
  output logic [VB_W-1:0]   vec_base_o,
  output logic [LW-1:0]     prio_off_o,
  output logic              auto_eoi_o,
  output logic              sfnm_o,
  output logic              smm_o
);

  localparam logic [DATA_W-1:0] CASC_BIT = DATA_W'(1) << CASCADE_LINE;

  cmd_t              dec;
  logic              run_ld, base_ld, mode_ld;
  logic [DATA_W-1:0] mask_q, isr_q;
  logic [VB_W-1:0]   vbase_q;
  logic [LW-1:0]     off_q;
  logic              aeoi_q, rot_aeoi_q, sfnm_q, smm_q, poll_q, rsel_isr_q;

  irq_cmd_decode u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .dec   (dec)
  );

  irq_cmd_init_seq u_seq (
    .clk             (clk),
    .rst             (rst),
    .start           (dec.start),
    .start_single    (wdata[1]),
    .start_need_mode (wdata[0]),
    .data_wr         (dec.data_wr),
    .run_ld          (run_ld),
    .base_ld         (base_ld),
    .mode_ld         (mode_ld)
  );

  irq_cmd_trig #(.DATA_W(DATA_W), .WR_MASK(TM_WR_MASK)) u_trig (
    .clk   (clk),
    .rst   (rst),
    .wr_en (tm_wr_en),
    .wdata (tm_wdata),
    .q     (tm_rdata)
  );

  // Priority resolution: pending requests, blocking in-service bits, EOI target
  logic [DATA_W-1:0] pend_vec, cur_vec;
  logic              pend_hit, cur_hit, eoi_hit;
  logic [LW-1:0]     pend_rank, cur_rank, eoi_rank;
  logic [LW-1:0]     pend_line, cur_line, eoi_line;
  logic              win_valid;

  always_comb begin
    pend_vec = req_in & ~mask_q;
    cur_vec  = isr_q;
    if (smm_q) cur_vec = cur_vec & ~mask_q;
    if (IS_PRIMARY && sfnm_q) cur_vec = cur_vec & ~CASC_BIT;
  end

  irq_cmd_prio #(.N(DATA_W)) u_pend (
    .vec (pend_vec), .base (off_q),
    .hit (pend_hit), .rank (pend_rank), .line (pend_line)
  );

  irq_cmd_prio #(.N(DATA_W)) u_cur (
    .vec (cur_vec), .base (off_q),
    .hit (cur_hit), .rank (cur_rank), .line (cur_line)
  );

  irq_cmd_prio #(.N(DATA_W)) u_eoi (
    .vec (isr_q), .base (off_q),
    .hit (eoi_hit), .rank (eoi_rank), .line (eoi_line)
  );

  assign win_valid = pend_hit & (~cur_hit | (pend_rank < cur_rank));

  logic poll_ack;
  assign poll_ack   = rd_en & ~wr_en & poll_q & win_valid;
  assign ack_valid  = poll_ack;
  assign ack_line   = pend_line;
  assign init_clear = dec.start;

  // Combinational read path
  always_comb begin
    if (poll_q) begin
      rdata = win_valid ? {1'b1, {(DATA_W-1-LW){1'b0}}, pend_line} : '0;
    end else if (addr) begin
      rdata = mask_q;
    end else begin
      rdata = rsel_isr_q ? isr_q : req_in;
    end
  end

  // Configuration and in-service state
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      isr_q      <= '0;
      vbase_q    <= '0;
      off_q      <= '0;
      aeoi_q     <= 1'b0;
      rot_aeoi_q <= 1'b0;
      sfnm_q     <= 1'b0;
      smm_q      <= 1'b0;
      poll_q     <= 1'b0;
      rsel_isr_q <= 1'b0;
    end else if (dec.start) begin
      mask_q     <= '0;
      isr_q      <= '0;
      off_q      <= '0;
      aeoi_q     <= 1'b0;
      rot_aeoi_q <= 1'b0;
      sfnm_q     <= 1'b0;
      smm_q      <= 1'b0;
      poll_q     <= 1'b0;
      rsel_isr_q <= 1'b0;
    end else if (dec.ctl) begin
      if (wdata[2]) poll_q     <= 1'b1;
      if (wdata[1]) rsel_isr_q <= wdata[0];
      if (wdata[6]) smm_q      <= wdata[5];
    end else if (dec.cmd) begin
      unique case (dec.op)
        OP_ROT_CLR, OP_ROT_SET: rot_aeoi_q <= wdata[7];
        OP_EOI_HP, OP_EOI_HP_ROT: begin
          if (eoi_hit) begin
            isr_q[eoi_line] <= 1'b0;
            if (dec.op == OP_EOI_HP_ROT) off_q <= eoi_line + 1'b1;
          end
        end
        OP_EOI_LINE: isr_q[dec.line] <= 1'b0;
        OP_SET_PRIO: off_q <= dec.line + 1'b1;
        OP_EOI_LINE_ROT: begin
          isr_q[dec.line] <= 1'b0;
          off_q           <= dec.line + 1'b1;
        end
        default: ;
      endcase
    end else if (dec.data_wr) begin
      if (run_ld)  mask_q  <= wdata;
      if (base_ld) vbase_q <= wdata[DATA_W-1:LW];
      if (mode_ld) begin
        sfnm_q <= wdata[4];
        aeoi_q <= wdata[1];
      end
    end else if (rd_en && poll_q) begin
      poll_q <= 1'b0;
      if (win_valid) begin
        if (aeoi_q) begin
          if (rot_aeoi_q) off_q <= pend_line + 1'b1;
        end else begin
          isr_q[pend_line] <= 1'b1;
        end
      end
    end
  end

  assign mask_o     = mask_q;
  assign isr_o      = isr_q;
  assign vec_base_o = vbase_q;
  assign prio_off_o = off_q;
  assign auto_eoi_o = aeoi_q;
  assign sfnm_o     = sfnm_q;
  assign smm_o      = smm_q;

endmodule

// File: rtl/irq_cmd_port_chk.sv
`timescale 1ns/1ps
module irq_cmd_port_chk #(
  parameter  int                DATA_W     = 8,
  parameter  logic [DATA_W-1:0] TM_WR_MASK = 8'hF8,
  localparam int                LW         = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              addr,
  input logic [3:0]        ctl,      // write data bits 6:3
  input logic              wd5,      // write data bit 5
  input logic [DATA_W-1:0] rdata,
  input logic              tm_wr_en,
  input logic [DATA_W-1:0] tm_wdata,
  input logic [DATA_W-1:0] tm_rdata,
  input logic              ack_valid,
  input logic [LW-1:0]     ack_line,
  input logic [DATA_W-1:0] mask_o,
  input logic [DATA_W-1:0] isr_o,
  input logic [LW-1:0]     prio_off_o,
  input logic              auto_eoi_o,
  input logic              smm_o
);

  logic is_start, is_ctl_smm;
  assign is_start   = wr_en && !addr && ctl[1];
  assign is_ctl_smm = wr_en && !addr && !ctl[1] && ctl[0] && ctl[3];

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_o == '0 && isr_o == '0 && prio_off_o == '0 && tm_rdata == '0));

  assert_init_clear_R2: assert property (@(posedge clk) disable iff (rst)
    is_start |=> (mask_o == '0 && isr_o == '0 && prio_off_o == '0 && !smm_o));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr || ctl[1])) |=> $stable(mask_o));

  assert_smm_load_R5: assert property (@(posedge clk) disable iff (rst)
    is_ctl_smm |=> (smm_o == $past(wd5)));

  assert_ack_format_R8: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (rd_en && rdata[DATA_W-1] && rdata[LW-1:0] == ack_line
                   && rdata[DATA_W-2:LW] == '0));

  assert_isr_set_only_by_ack_R8: assert property (@(posedge clk) disable iff (rst)
    !ack_valid |=> ((isr_o & ~$past(isr_o)) == '0));

  assert_auto_eoi_no_isr_R10: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && auto_eoi_o) |=> $stable(isr_o));

  assert_trig_write_R12: assert property (@(posedge clk) disable iff (rst)
    tm_wr_en |=> (tm_rdata == ($past(tm_wdata) & TM_WR_MASK)));

endmodule

bind irq_cmd_port irq_cmd_port_chk #(.DATA_W(DATA_W), .TM_WR_MASK(TM_WR_MASK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .ctl        (wdata[6:3]),
  .wd5        (wdata[5]),
  .rdata      (rdata),
  .tm_wr_en   (tm_wr_en),
  .tm_wdata   (tm_wdata),
  .tm_rdata   (tm_rdata),
  .ack_valid  (ack_valid),
  .ack_line   (ack_line),
  .mask_o     (mask_o),
  .isr_o      (isr_o),
  .prio_off_o (prio_off_o),
  .auto_eoi_o (auto_eoi_o),
  .smm_o      (smm_o)
);

// File: tb/test_irq_cmd_port.sv
`timescale 1ns/1ps
module test_irq_cmd_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       tm_wr_en = 1'b0;
  logic [7:0] tm_wdata = '0, tm_rdata;
  logic [7:0] req_in = '0;
  logic       ack_valid, init_clear, auto_eoi_o, sfnm_o, smm_o;
  logic [2:0] ack_line, prio_off_o;
  logic [7:0] mask_o, isr_o;
  logic [4:0] vec_base_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_cmd_port i_irq_cmd_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tm_wr_en(tm_wr_en), .tm_wdata(tm_wdata),
    .tm_rdata(tm_rdata), .req_in(req_in), .ack_valid(ack_valid),
    .ack_line(ack_line), .init_clear(init_clear), .mask_o(mask_o),
    .isr_o(isr_o), .vec_base_o(vec_base_o), .prio_off_o(prio_off_o),
    .auto_eoi_o(auto_eoi_o), .sfnm_o(sfnm_o), .smm_o(smm_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tm_wr(input logic [7:0] d);
    @(negedge clk);
    tm_wdata = d; tm_wr_en = 1'b1;
    @(negedge clk);
    tm_wr_en = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Issue a poll control word, then a read strobe; check the byte and acknowledge
  task automatic poll_chk(input string req, input logic [7:0] exp);
    logic [7:0] d;
    logic       av;
    logic [2:0] al;
    bus_wr(1'b0, 8'h0C);
    @(negedge clk);
    addr = 1'b0; rd_en = 1'b1;
    #1;
    d = rdata; av = ack_valid; al = ack_line;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, "poll byte", d, exp);
    chk(req, "ack_valid", av, exp[7]);
    if (exp[7]) chk(req, "ack_line", al, exp[2:0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Cascaded start with a mode word, vector base 0
  task automatic init_casc(input logic [7:0] mode_word);
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b1, 8'h04);
    bus_wr(1'b1, mode_word);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    req_in = 8'h5A;
    chk("R1", "mask", mask_o, 0);
    chk("R1", "isr", isr_o, 0);
    chk("R1", "offset", prio_off_o, 0);
    chk("R1", "trig", tm_rdata, 0);
    chk("R1", "modes", {auto_eoi_o, sfnm_o, smm_o}, 0);
    peek(1'b0, d); chk("R1", "addr0 read req", d, 8'h5A);
    bus_wr(1'b1, 8'h3C);
    chk("R1", "run step loads mask", mask_o, 8'h3C);
  endtask

  task automatic t_init_paths();
    // cascaded with mode word
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b1, 8'h43);
    chk("R3", "base loaded", vec_base_o, 8);
    chk("R3", "mask untouched at base", mask_o, 0);
    bus_wr(1'b1, 8'h04);
    chk("R3", "mask untouched at link", mask_o, 0);
    bus_wr(1'b1, 8'h12);
    chk("R3", "sfnm from mode word", sfnm_o, 1);
    chk("R3", "aeoi from mode word", auto_eoi_o, 1);
    bus_wr(1'b1, 8'hA5);
    chk("R3", "mask after cascade+mode", mask_o, 8'hA5);
    // single with mode word
    bus_wr(1'b0, 8'h13);
    bus_wr(1'b1, 8'h20);
    chk("R3", "base single", vec_base_o, 4);
    bus_wr(1'b1, 8'h02);
    chk("R3", "mode step after single base", {sfnm_o, auto_eoi_o}, 2'b01);
    chk("R3", "mask not loaded by mode", mask_o, 0);
    bus_wr(1'b1, 8'h0F);
    chk("R3", "mask after single+mode", mask_o, 8'h0F);
    // single, no mode word
    bus_wr(1'b0, 8'h12);
    bus_wr(1'b1, 8'h88);
    chk("R3", "base single no mode", vec_base_o, 17);
    bus_wr(1'b1, 8'h33);
    chk("R3", "mask right after base", mask_o, 8'h33);
    chk("R3", "aeoi stays clear", auto_eoi_o, 0);
    // cascaded, no mode word
    bus_wr(1'b0, 8'h10);
    bus_wr(1'b1, 8'hFF);
    bus_wr(1'b1, 8'h00);
    chk("R3", "link skips mode", mask_o, 0);
    bus_wr(1'b1, 8'h3C);
    chk("R3", "mask after cascade no mode", mask_o, 8'h3C);
    chk("R3", "base cascade no mode", vec_base_o, 31);
  endtask

  task automatic t_init_clear();
    logic [7:0] d;
    init_casc(8'h00);
    req_in = 8'h01;
    poll_chk("R2", 8'h80);
    bus_wr(1'b0, 8'hC2);        // offset 3
    bus_wr(1'b0, 8'h68);        // special mask on
    bus_wr(1'b1, 8'hFF);
    tm_wr(8'hFF);
    bus_wr(1'b0, 8'h0C);        // poll pending
    chk("R2", "setup isr", isr_o, 8'h01);
    chk("R2", "setup offset", prio_off_o, 3);
    @(negedge clk);
    addr = 1'b0; wdata = 8'h11; wr_en = 1'b1;
    #1;
    chk("R2", "init_clear pulse", init_clear, 1);
    chk("R13", "mask unchanged before edge", mask_o, 8'hFF);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R2", "init_clear drops", init_clear, 0);
    chk("R2", "mask cleared", mask_o, 0);
    chk("R2", "isr cleared", isr_o, 0);
    chk("R2", "offset cleared", prio_off_o, 0);
    chk("R2", "smm cleared", smm_o, 0);
    chk("R2", "trig preserved", tm_rdata, 8'hF8);
    peek(1'b0, d); chk("R2", "poll cleared, reads req", d, 8'h01);
    bus_wr(1'b1, 8'h00); bus_wr(1'b1, 8'h04); bus_wr(1'b1, 8'h00);
  endtask

  task automatic t_poll_nest();
    logic [7:0] d;
    init_casc(8'h00);
    req_in = 8'h24;
    poll_chk("R8", 8'h82);
    chk("R8", "isr set by ack", isr_o, 8'h04);
    poll_chk("R9", 8'h00);
    chk("R9", "isr kept on no winner", isr_o, 8'h04);
    peek(1'b0, d); chk("R8", "poll cleared after read", d, 8'h24);
    req_in = 8'h03;
    poll_chk("R9", 8'h80);
    chk("R9", "nested isr", isr_o, 8'h05);
    bus_wr(1'b1, 8'h01);
    req_in = 8'h03;
    bus_wr(1'b0, 8'h20);
    chk("R6", "nonspecific clears line 0", isr_o, 8'h04);
    poll_chk("R9", 8'h81);
  endtask

  task automatic t_eoi();
    init_casc(8'h00);
    req_in = 8'h04; poll_chk("R6", 8'h82);
    req_in = 8'h01; poll_chk("R6", 8'h80);
    chk("R6", "isr two lines", isr_o, 8'h05);
    bus_wr(1'b0, 8'h20);
    chk("R6", "code1 clears top", isr_o, 8'h04);
    chk("R6", "code1 keeps offset", prio_off_o, 0);
    bus_wr(1'b0, 8'hA0);
    chk("R6", "code5 clears", isr_o, 8'h00);
    chk("R6", "code5 rotates", prio_off_o, 3);
    req_in = 8'h11;
    poll_chk("R9", 8'h84);
    chk("R9", "rotated winner in service", isr_o, 8'h10);
    // nonspecific EOI under a rotated offset
    init_casc(8'h00);
    req_in = 8'h02; poll_chk("R6", 8'h81);
    bus_wr(1'b0, 8'hC4);
    chk("R7", "code6 offset", prio_off_o, 5);
    req_in = 8'h40; poll_chk("R6", 8'h86);
    chk("R6", "isr under offset", isr_o, 8'h42);
    bus_wr(1'b0, 8'h20);
    chk("R6", "code1 picks rank not line", isr_o, 8'h02);
  endtask

  task automatic t_specific();
    init_casc(8'h00);
    req_in = 8'h10; poll_chk("R7", 8'h84);
    bus_wr(1'b0, 8'h64);
    chk("R7", "code3 clears line 4", isr_o, 8'h00);
    bus_wr(1'b0, 8'hC5);
    chk("R7", "code6 offset 6", prio_off_o, 6);
    req_in = 8'h80; poll_chk("R7", 8'h87);
    bus_wr(1'b0, 8'hE7);
    chk("R7", "code7 clears line 7", isr_o, 8'h00);
    chk("R7", "code7 offset", prio_off_o, 0);
    req_in = 8'h02; poll_chk("R7", 8'h81);
    bus_wr(1'b0, 8'h40);
    chk("R7", "code2 isr kept", isr_o, 8'h02);
    chk("R7", "code2 offset kept", prio_off_o, 0);
  endtask

  task automatic t_read_select();
    logic [7:0] d;
    init_casc(8'h00);
    req_in = 8'h08; poll_chk("R4", 8'h83);
    req_in = 8'h30;
    bus_wr(1'b0, 8'h0B);
    peek(1'b0, d); chk("R4", "select isr", d, 8'h08);
    bus_wr(1'b0, 8'h09);
    peek(1'b0, d); chk("R4", "bit1 clear keeps isr", d, 8'h08);
    bus_wr(1'b0, 8'h0A);
    peek(1'b0, d); chk("R4", "select req", d, 8'h30);
    bus_wr(1'b1, 8'h5C);
    peek(1'b1, d); chk("R13", "addr1 reads mask same cycle", d, 8'h5C);
    peek(1'b0, d); chk("R13", "addr0 same cycle", d, 8'h30);
  endtask

  task automatic t_special_mask();
    init_casc(8'h00);
    req_in = 8'h01; poll_chk("R9", 8'h80);
    bus_wr(1'b1, 8'h01);
    req_in = 8'h02;
    poll_chk("R5", 8'h00);
    bus_wr(1'b0, 8'h68);
    chk("R5", "smm set", smm_o, 1);
    poll_chk("R5", 8'h81);
    chk("R5", "isr after smm ack", isr_o, 8'h03);
    bus_wr(1'b0, 8'h28);
    chk("R5", "bit6 clear keeps smm", smm_o, 1);
    bus_wr(1'b0, 8'h48);
    chk("R5", "smm cleared", smm_o, 0);
  endtask

  task automatic t_auto_eoi();
    init_casc(8'h02);
    chk("R10", "aeoi on", auto_eoi_o, 1);
    bus_wr(1'b0, 8'h80);
    req_in = 8'h08; poll_chk("R10", 8'h83);
    chk("R10", "isr not set", isr_o, 0);
    chk("R10", "rotate on ack", prio_off_o, 4);
    bus_wr(1'b0, 8'h00);
    req_in = 8'h20; poll_chk("R10", 8'h85);
    chk("R10", "no rotate after code0", prio_off_o, 4);
    chk("R10", "isr still clear", isr_o, 0);
  endtask

  task automatic t_sfnm();
    init_casc(8'h10);
    chk("R11", "sfnm on", sfnm_o, 1);
    req_in = 8'h04;
    poll_chk("R11", 8'h82);
    poll_chk("R11", 8'h82);
    chk("R11", "cascade isr", isr_o, 8'h04);
    init_casc(8'h00);
    poll_chk("R11", 8'h82);
    poll_chk("R11", 8'h00);
  endtask

  task automatic t_trig();
    tm_wr(8'hFF);
    chk("R12", "writable bits only", tm_rdata, 8'hF8);
    tm_wr(8'h0F);
    chk("R12", "low bits dropped", tm_rdata, 8'h08);
    do_reset();
    chk("R12", "reset clears trig", tm_rdata, 0);
    chk("R1", "reset clears mask", mask_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_init_paths();
    t_init_clear();
    t_poll_nest();
    t_eoi();
    t_specific();
    t_read_select();
    t_special_mask();
    t_auto_eoi();
    t_sfnm();
    t_trig();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule